// File: doc/BRIEF.md
# RGB LED Matrix Column Scanner

This block lights a multiplexed RGB LED matrix of 11 columns by 10 rows from a free-running system clock, which is 25 MHz in the target system. The rest of the chip presents the picture as three flat, active-high frame vectors: one for red, one for green and one for blue. Each vector holds 110 bits, and the bit for a pixel sits at index `column*10 + row`. The scanner shows one column at a time. It drives a 4-bit binary column address and three 10-bit active-low row vectors, then steps to the next column. Codes 0 to 10 on the address enable that column, and any code from 11 to 15 turns the whole matrix off.

A prescaler sets how long each column stays on. The default of 25,000 clocks gives 1 ms per column, which is a refresh rate of about 91 Hz for the full frame. The first few clocks of every column slot are blanking clocks: the address is held at the off code 15 and every row is driven high. This keeps the previous column's pattern from ghosting into the next one. The column counter wraps from 10 back to 0, so the codes 11 to 14 never appear on the address.

A build-time switch selects single-colour mode. In this mode the red frame vector is the only input used, as a lit/unlit map. Every lit pixel shows one fixed 3-bit colour, where bit 2 is red, bit 1 is green and bit 0 is blue. Because each channel is either on or off, only eight colours can be shown. The frame inputs are plain level signals that are sampled every clock. They have no valid/ready handshake, so back-pressure does not apply: a new picture takes effect on the next clock.

Top module: `rgb_matrix_scanner`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `col_addr` is 15 and every bit of `row_red_n`, `row_green_n` and `row_blue_n` is 1.
- R2: Count n clock edges after reset is released, with n >= 1. Column slot k = (n-1)/DWELL_CLKS wraps modulo 11, so the columns appear in the order 0, 1, ..., 10, 0, and each slot lasts exactly DWELL_CLKS clocks.
- R3: In the first BLANK_CLKS clocks of every column slot, `col_addr` is 15 and all row outputs are 1. The address never changes from one column to another without passing through 15.
- R4: `col_addr` only takes the values 0 to 10 or 15. The codes 11 to 14 never appear.
- R5: In RGB mode (SINGLE_COLOR=0), while column c is shown, bit r of `row_red_n` is the inverse of `red_frame[c*10+r]`. Green and blue follow the same rule with their own frames, so 0 means lit.
- R6: In single-colour mode (SINGLE_COLOR=1), for column c and row r, the lit flag is `red_frame[c*10+r]`. The red row bit is 0 only if the pixel is lit and SOLID_RGB[2] is 1. Green uses SOLID_RGB[1] and blue uses SOLID_RGB[0] in the same way. Unlit pixels keep all three row bits at 1.
- R7: In single-colour mode, the values on `green_frame` and `blue_frame` have no effect on any output.
- R8: A change on a frame input appears on the row outputs one clock later, as long as the column is not in blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| red_frame | input | 110 | Active-high red picture, bit index column*10+row; lit map in single-colour mode |
| green_frame | input | 110 | Active-high green picture, same indexing |
| blue_frame | input | 110 | Active-high blue picture, same indexing |
| col_addr | output | 4 | Binary column select; 0 to 10 enable a column, 15 means off |
| row_red_n | output | 10 | Active-low red row drives, bit index = row |
| row_green_n | output | 10 | Active-low green row drives, bit index = row |
| row_blue_n | output | 10 | Active-low blue row drives, bit index = row |

## Verification
The bench builds two copies of the scanner, both with DWELL_CLKS=5 and BLANK_CLKS=2. With these values a full 11-column frame takes 55 clocks, so the bench can walk every column slot, its blanking clocks and the wrap from 10 back to 0 several times per picture. One copy runs in RGB mode. The other runs in single-colour mode with SOLID_RGB=3'b101, so one channel stays dark while two follow the lit map. That copy is fed green and blue frames that differ from its red frame, which shows whether those two inputs leak through to the outputs.

// File: rtl/rgbscan_pkg.sv
package rgbscan_pkg;

  // Display phase inside one column slot.
  typedef enum logic {
    PH_BLANK = 1'b0,
    PH_SHOW  = 1'b1
  } scan_phase_e;

  // One pixel's colour: each channel is simply on or off.
  typedef struct packed {
    logic r;
    logic g;
    logic b;
  } rgb_bits_t;

endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import rgbscan_pkg::*;
#(
  parameter int NUM_COLS   = 11,
  parameter int DWELL_CLKS = 25000,
  parameter int BLANK_CLKS = 1,
  localparam int CNT_W     = (DWELL_CLKS > 1) ? $clog2(DWELL_CLKS) : 1,
  localparam int COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] col_idx,
  output scan_phase_e      phase
);

  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(DWELL_CLKS - 1);
  localparam logic [CNT_W-1:0] SHOW_FROM = CNT_W'(BLANK_CLKS);
  localparam logic [COL_W-1:0] LAST_COL  = COL_W'(NUM_COLS - 1);

  logic [CNT_W-1:0] tick_q;
  logic [COL_W-1:0] col_q;

  // Dwell prescaler and column counter; the column wraps after the last one.
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      col_q  <= '0;
    end else if (tick_q == LAST_TICK) begin
      tick_q <= '0;
      col_q  <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign col_idx = col_q;
  assign phase   = (tick_q < SHOW_FROM) ? PH_BLANK : PH_SHOW;

endmodule

// File: rtl/column_slicer.sv
module column_slicer
  import rgbscan_pkg::*;
#(
  parameter int        NUM_ROWS     = 10,
  parameter int        NUM_COLS     = 11,
  parameter bit        SINGLE_COLOR = 1'b0,
  parameter rgb_bits_t SOLID_RGB    = 3'b111,
  localparam int       PIXELS       = NUM_ROWS * NUM_COLS,
  localparam int       COL_W        = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int       PIX_W        = $clog2(PIXELS)
) (
  input  logic [COL_W-1:0]    col_idx,
  input  logic [PIXELS-1:0]   red_frame,
  input  logic [PIXELS-1:0]   green_frame,
  input  logic [PIXELS-1:0]   blue_frame,
  output logic [NUM_ROWS-1:0] red_on,
  output logic [NUM_ROWS-1:0] green_on,
  output logic [NUM_ROWS-1:0] blue_on
);

  logic [PIX_W-1:0]    base;
  logic [NUM_ROWS-1:0] red_sel;
  logic [NUM_ROWS-1:0] green_sel;
  logic [NUM_ROWS-1:0] blue_sel;

  // Column-major layout: the column's rows are contiguous bits.
  assign base = PIX_W'(col_idx) * PIX_W'(NUM_ROWS);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [PIX_W-1:0] idx;
    assign idx          = base + PIX_W'(r);
    assign red_sel[r]   = red_frame[idx];
    assign green_sel[r] = green_frame[idx];
    assign blue_sel[r]  = blue_frame[idx];
  end

  if (SINGLE_COLOR) begin : g_single
    // Red frame is the lit map; the fixed colour gates each channel.
    assign red_on   = red_sel & {NUM_ROWS{SOLID_RGB.r}};
    assign green_on = red_sel & {NUM_ROWS{SOLID_RGB.g}};
    assign blue_on  = red_sel & {NUM_ROWS{SOLID_RGB.b}};
  end else begin : g_rgb
    assign red_on   = red_sel;
    assign green_on = green_sel;
    assign blue_on  = blue_sel;
  end

endmodule

// File: rtl/row_driver.sv
module row_driver
  import rgbscan_pkg::*;
#(
  parameter int  NUM_ROWS = 10,
  parameter int  ADDR_W   = 4,
  parameter int  COL_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  scan_phase_e         phase,
  input  logic [COL_W-1:0]    col_idx,
  input  logic [NUM_ROWS-1:0] red_on,
  input  logic [NUM_ROWS-1:0] green_on,
  input  logic [NUM_ROWS-1:0] blue_on,
  output logic [ADDR_W-1:0]   col_addr,
  output logic [NUM_ROWS-1:0] row_red_n,
  output logic [NUM_ROWS-1:0] row_green_n,
  output logic [NUM_ROWS-1:0] row_blue_n
);

  localparam logic [ADDR_W-1:0] OFF_CODE = '1;

  // Registered outputs: blank (off code, rows high) or the column pattern inverted.
  always_ff @(posedge clk) begin
    if (rst || phase == PH_BLANK) begin
      col_addr    <= OFF_CODE;
      row_red_n   <= '1;
      row_green_n <= '1;
      row_blue_n  <= '1;
    end else begin
      col_addr    <= ADDR_W'(col_idx);
      row_red_n   <= ~red_on;
      row_green_n <= ~green_on;
      row_blue_n  <= ~blue_on;
    end
  end

endmodule

// File: rtl/rgb_matrix_scanner.sv
module rgb_matrix_scanner
  import rgbscan_pkg::*;
#(
  parameter int        NUM_ROWS     = 10,
  parameter int        NUM_COLS     = 11,
  parameter int        ADDR_W       = 4,
  parameter int        DWELL_CLKS   = 25000,
  parameter int        BLANK_CLKS   = 1,
  parameter bit        SINGLE_COLOR = 1'b0,
  parameter rgb_bits_t SOLID_RGB    = 3'b111,
  localparam int       PIXELS       = NUM_ROWS * NUM_COLS,
  localparam int       COL_W        = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PIXELS-1:0]   red_frame,
  input  logic [PIXELS-1:0]   green_frame,
  input  logic [PIXELS-1:0]   blue_frame,
  output logic [ADDR_W-1:0]   col_addr,
  output logic [NUM_ROWS-1:0] row_red_n,
  output logic [NUM_ROWS-1:0] row_green_n,
  output logic [NUM_ROWS-1:0] row_blue_n
);

  initial begin
    if (NUM_COLS >= (1 << ADDR_W)) $error("column count leaves no off code");
    if (BLANK_CLKS < 1 || BLANK_CLKS >= DWELL_CLKS) $error("blanking must fit inside the dwell");
  end

  logic [COL_W-1:0]    col_idx;
  scan_phase_e         phase;
  logic [NUM_ROWS-1:0] red_on, green_on, blue_on;

  scan_timer #(
    .NUM_COLS  (NUM_COLS),
    .DWELL_CLKS(DWELL_CLKS),
    .BLANK_CLKS(BLANK_CLKS)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .col_idx(col_idx),
    .phase  (phase)
  );

  column_slicer #(
    .NUM_ROWS    (NUM_ROWS),
    .NUM_COLS    (NUM_COLS),
    .SINGLE_COLOR(SINGLE_COLOR),
    .SOLID_RGB   (SOLID_RGB)
  ) slicer_i (
    .col_idx    (col_idx),
    .red_frame  (red_frame),
    .green_frame(green_frame),
    .blue_frame (blue_frame),
    .red_on     (red_on),
    .green_on   (green_on),
    .blue_on    (blue_on)
  );

  row_driver #(
    .NUM_ROWS(NUM_ROWS),
    .ADDR_W  (ADDR_W),
    .COL_W   (COL_W)
  ) driver_i (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .col_idx    (col_idx),
    .red_on     (red_on),
    .green_on   (green_on),
    .blue_on    (blue_on),
    .col_addr   (col_addr),
    .row_red_n  (row_red_n),
    .row_green_n(row_green_n),
    .row_blue_n (row_blue_n)
  );

endmodule

// File: rtl/rgb_matrix_scanner_chk.sv
module rgb_matrix_scanner_chk #(
  parameter int       NUM_ROWS     = 10,
  parameter int       NUM_COLS     = 11,
  parameter int       ADDR_W       = 4,
  parameter bit       SINGLE_COLOR = 1'b0,
  parameter bit [2:0] SOLID_RGB    = 3'b111
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   col_addr,
  input logic [NUM_ROWS-1:0] row_red_n,
  input logic [NUM_ROWS-1:0] row_green_n,
  input logic [NUM_ROWS-1:0] row_blue_n
);

  localparam logic [ADDR_W-1:0] OFF_CODE = '1;
  localparam logic [ADDR_W-1:0] LAST_COL = ADDR_W'(NUM_COLS - 1);

  // Last column actually shown, to check the order of columns (R2).
  logic [ADDR_W-1:0] last_col;
  always_ff @(posedge clk) begin
    if (rst) last_col <= LAST_COL;
    else if (col_addr != OFF_CODE) last_col <= col_addr;
  end

  // R1: the clock after a reset edge shows a dark, deselected matrix.
  p_reset_dark_r1: assert property (@(posedge clk)
    rst |=> (col_addr == OFF_CODE && &row_red_n && &row_green_n && &row_blue_n));

  // R2: a newly shown column follows the previously shown one, wrapping after the last.
  p_sequence_r2: assert property (@(posedge clk) disable iff (rst)
    (col_addr != OFF_CODE && $past(col_addr) == OFF_CODE && !$past(rst))
      |-> col_addr == ((last_col == LAST_COL) ? '0 : last_col + 1'b1));

  // R3: a shown column either stays or goes to the off code, never straight to another.
  p_blank_between_r3: assert property (@(posedge clk) disable iff (rst)
    (col_addr != OFF_CODE) |=> (col_addr == $past(col_addr) || col_addr == OFF_CODE));

  // R3: the off code always comes with every row dark.
  p_blank_dark_r3: assert property (@(posedge clk) disable iff (rst)
    (col_addr == OFF_CODE) |-> (&row_red_n && &row_green_n && &row_blue_n));

  // R4: only real columns or the off code appear.
  p_addr_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (col_addr <= LAST_COL || col_addr == OFF_CODE));

  // R6: in single-colour mode a disabled channel never lights.
  p_single_dark_r6: assert property (@(posedge clk) disable iff (rst)
    SINGLE_COLOR |-> ((SOLID_RGB[2] || &row_red_n) &&
                      (SOLID_RGB[1] || &row_green_n) &&
                      (SOLID_RGB[0] || &row_blue_n)));

endmodule

bind rgb_matrix_scanner rgb_matrix_scanner_chk #(
  .NUM_ROWS    (NUM_ROWS),
  .NUM_COLS    (NUM_COLS),
  .ADDR_W      (ADDR_W),
  .SINGLE_COLOR(SINGLE_COLOR),
  .SOLID_RGB   (SOLID_RGB)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .col_addr   (col_addr),
  .row_red_n  (row_red_n),
  .row_green_n(row_green_n),
  .row_blue_n (row_blue_n)
);

// File: tb/rgb_matrix_scanner_tb_top.sv
`timescale 1ns/1ps
module rgb_matrix_scanner_tb_top;

  localparam int ROWS   = 10;
  localparam int COLS   = 11;
  localparam int PIX    = ROWS * COLS;
  localparam int DWELL  = 5;
  localparam int BLANK  = 2;
  localparam logic [2:0] SOLID = 3'b101;
  localparam int FRAME_CLKS = DWELL * COLS;

  // Stimulus table: kind 0 = hashed from seed, 1 = all lit, 2 = all dark.
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] seed;
    logic [7:0]  frames;
  } vec_t;

  localparam vec_t TABLE [6] = '{
    '{kind: 2'd0, seed: 32'h1234_5678, frames: 8'd2},
    '{kind: 2'd1, seed: 32'h0,         frames: 8'd1},
    '{kind: 2'd2, seed: 32'h0,         frames: 8'd1},
    '{kind: 2'd0, seed: 32'hDEAD_BEEF, frames: 8'd2},
    '{kind: 2'd0, seed: 32'h0F0F_00FF, frames: 8'd1},
    '{kind: 2'd0, seed: 32'h5555_AAAA, frames: 8'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PIX-1:0] red_f = '0, green_f = '0, blue_f = '0;
  logic [PIX-1:0] sg_green = '0, sg_blue = '0;

  logic [3:0]      a_addr, s_addr;
  logic [ROWS-1:0] a_r, a_g, a_b, s_r, s_g, s_b;

  int errors = 0;
  int checks = 0;
  int n_edges = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) n_edges <= 0;
    else     n_edges <= n_edges + 1;
  end

  rgb_matrix_scanner #(
    .NUM_ROWS(ROWS), .NUM_COLS(COLS), .ADDR_W(4),
    .DWELL_CLKS(DWELL), .BLANK_CLKS(BLANK),
    .SINGLE_COLOR(1'b0), .SOLID_RGB(3'b111)
  ) dut_i (
    .clk(clk), .rst(rst),
    .red_frame(red_f), .green_frame(green_f), .blue_frame(blue_f),
    .col_addr(a_addr), .row_red_n(a_r), .row_green_n(a_g), .row_blue_n(a_b)
  );

  rgb_matrix_scanner #(
    .NUM_ROWS(ROWS), .NUM_COLS(COLS), .ADDR_W(4),
    .DWELL_CLKS(DWELL), .BLANK_CLKS(BLANK),
    .SINGLE_COLOR(1'b1), .SOLID_RGB(SOLID)
  ) dut_single_i (
    .clk(clk), .rst(rst),
    .red_frame(red_f), .green_frame(sg_green), .blue_frame(sg_blue),
    .col_addr(s_addr), .row_red_n(s_r), .row_green_n(s_g), .row_blue_n(s_b)
  );

  function automatic logic [PIX-1:0] make_frame(vec_t v, logic [31:0] salt);
    logic [PIX-1:0] f;
    logic [31:0] s;
    if (v.kind == 2'd1) return '1;
    if (v.kind == 2'd2) return '0;
    s = v.seed ^ salt;
    for (int i = 0; i < PIX; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      f[i] = s[16];
    end
    return f;
  endfunction

  task automatic report(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at edge %0d", req, act, exp, n_edges);
    end
  endtask

  // Compare both copies against the model for the current edge count.
  task automatic check_cycle(string tag);
    int c, col;
    logic blank;
    logic [3:0] e_addr;
    logic [ROWS-1:0] er, eg, eb, sr, sgr, sb;
    blank = 1'b1; col = 0;
    if (n_edges > 0) begin
      c = (n_edges - 1) % DWELL;
      col = ((n_edges - 1) / DWELL) % COLS;
      blank = (c < BLANK);
    end
    e_addr = blank ? 4'hF : 4'(col);
    for (int r = 0; r < ROWS; r++) begin
      logic lit;
      lit   = red_f[col*ROWS + r];
      er[r] = blank | ~red_f[col*ROWS + r];
      eg[r] = blank | ~green_f[col*ROWS + r];
      eb[r] = blank | ~blue_f[col*ROWS + r];
      sr[r]  = blank | ~(lit & SOLID[2]);
      sgr[r] = blank | ~(lit & SOLID[1]);
      sb[r]  = blank | ~(lit & SOLID[0]);
    end
    report({tag, " addr"}, 32'(a_addr), 32'(e_addr));
    report({tag, " rgb rows"}, {2'b0, a_r, a_g, a_b}, {2'b0, er, eg, eb});
    report({tag, " single addr"}, 32'(s_addr), 32'(e_addr));
    report({tag, " single rows"}, {2'b0, s_r, s_g, s_b}, {2'b0, sr, sgr, sb});
  endtask

  task automatic do_reset(int cycles);
    @(negedge clk);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    // R1: during reset the outputs are dark and deselected.
    report("R1 addr in reset", 32'(a_addr), 32'hF);
    report("R1 rows in reset", {2'b0, a_r, a_g, a_b}, {32{1'b1}} >> 2);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(3);
    // Table walk: R2, R3, R4, R5, R6, R7 checked every clock.
    for (int t = 0; t < 6; t++) begin
      red_f    = make_frame(TABLE[t], 32'h1);
      green_f  = make_frame(TABLE[t], 32'h2);
      blue_f   = make_frame(TABLE[t], 32'h3);
      // R7: single-colour copy gets unrelated green/blue frames.
      sg_green = ~green_f ^ make_frame(TABLE[t], 32'h77);
      sg_blue  = make_frame(TABLE[t], 32'h99);
      for (int k = 0; k < int'(TABLE[t].frames) * FRAME_CLKS; k++) begin
        @(negedge clk);
        check_cycle("R2/R3/R5/R6 table");
      end
    end

    // R1: reset in the middle of a column, first clock after release is dark.
    do_reset(1);
    @(negedge clk);
    check_cycle("R1 after release");
    report("R1 first clock addr", 32'(a_addr), 32'hF);

    // R8: change the frame during a show phase; takes effect one clock later.
    for (int k = 0; k < DWELL + BLANK; k++) @(negedge clk);
    red_f   = ~red_f;
    green_f = ~green_f;
    blue_f  = ~blue_f;
    @(negedge clk);
    check_cycle("R8 frame change");

    // R7: toggle green/blue on the single-colour copy only; its rows must not move.
    for (int k = 0; k < FRAME_CLKS; k++) begin
      sg_green = ~sg_green;
      sg_blue  = sg_blue ^ make_frame(TABLE[0], 32'(k));
      @(negedge clk);
      check_cycle("R7 ignored inputs");
    end

    // R4/R2: run past the wrap from column 10 to 0 and confirm column 0 returns.
    for (int k = 0; k < 2 * FRAME_CLKS; k++) begin
      @(negedge clk);
      check_cycle("R4 wrap");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule